// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when a 128Mb-class SDRAM gets its AUTO REFRESH commands. Every row must be refreshed once per refresh period. The device keeps its own row counter, so the block only produces command strobes and no address. Each refresh is prepared with a PRECHARGE of all banks. The AUTO REFRESH follows once the precharge time has passed.

A mode input picks one of two schedules:

- **Distributed:** one refresh every period/N cycles.
- **Burst:** N refreshes back to back, spaced by the row cycle time, once per period.

The scheduler never takes the memory on its own. It raises a request and waits until the main controller grants the bus. Refreshes that fall due while the grant is withheld are kept in a debt counter. That counter saturates at N.

A separate request moves the device into self refresh. The block closes all banks, then issues the refresh command with CKE driven low, and holds CKE low for as long as the request stays high. When the request drops, CKE rises. Ready returns one row cycle time later, and the refresh interval timer starts again from zero.

Top module: `sdram_refresh_sched`

## Requirements
- R1: In distributed mode, one refresh falls due every T_REF_CYC/N_REF cycles. With the grant held high, the first AUTO REFRESH strobe comes in the cycle INTERVAL+5 after reset release, where cycle k is the state after the k-th rising edge. Later strobes follow every INTERVAL cycles.
- R2: In burst mode, N_REF refreshes fall due once every T_REF_CYC cycles. With the grant held, they are issued as a run in which consecutive AUTO REFRESH strobes are exactly T_RC cycles apart. The first strobe comes in cycle T_REF_CYC+5, and the next run starts one period after the previous one.
- R3: Every refresh run begins with a one-cycle PRECHARGE-all strobe. Its AUTO REFRESH strobe follows exactly T_RP cycles later.
- R4: A sequence starts only after grant_i is seen high while ref_req_o is high. No command strobe appears while ref_req_o is low. ref_req_o stays high while work is pending and no grant has come.
- R5: Pending refreshes never exceed N_REF. Refreshes that fall due while the debt is already N_REF are dropped.
- R6: At most one of pre_all_o, aref_o and sref_enter_o is high in any cycle.
- R7: A self-refresh request takes priority over refresh work. The block issues PRECHARGE-all, then T_RP cycles later a sref_enter_o strobe with cke_o low in the same cycle. cke_o stays low, and no other command is issued, while sref_req_i remains high.
- R8: After sref_req_i falls, cke_o is high from the next cycle. ready_o rises exactly T_RC cycles after cke_o rises. Pending debt is cleared, and the next distributed refresh comes a full interval (plus the 5-cycle sequence latency) after ready_o rises.
- R9: During reset, cke_o and ready_o are high, and ref_req_o and all command strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode_i | input | 1 | 1 selects the burst schedule, 0 the distributed schedule |
| grant_i | input | 1 | Main controller grants the memory to the scheduler |
| sref_req_i | input | 1 | Hold high to keep the device in self refresh |
| ref_req_o | output | 1 | Scheduler wants, or currently owns, the memory |
| pre_all_o | output | 1 | One-cycle PRECHARGE with all-banks select |
| aref_o | output | 1 | One-cycle AUTO REFRESH command |
| sref_enter_o | output | 1 | One-cycle refresh command issued with CKE low (self-refresh entry) |
| cke_o | output | 1 | Clock enable to the device |
| ready_o | output | 1 | Low from self-refresh entry until T_RC cycles after CKE returns |

## Verification
The hardest situation to reach from the ports is a saturated debt counter: the pins show neither the debt nor its limit. The bench withholds the grant for twenty intervals in distributed mode, and for three periods in burst mode, then releases it. It counts the AUTO REFRESH strobes in a fixed window afterwards. A counter that kept every missed refresh would issue many more strobes in that window than the N_REF-bounded figure. Self-refresh exit timing is checked by dropping the request at a known cycle. The bench then locates the CKE rise, the ready rise and the first refresh after the restarted interval.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RC,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } sched_state_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int unsigned T_REF_CYC = 3_200_000,
    parameter int unsigned N_REF     = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode_i,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned INTERVAL = T_REF_CYC / N_REF;
    localparam int unsigned TW       = $clog2(T_REF_CYC + 1);
    localparam logic [TW-1:0] LIM_DIST  = TW'(INTERVAL - 1);
    localparam logic [TW-1:0] LIM_BURST = TW'(T_REF_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] limit;

    always_comb begin
        limit  = burst_mode_i ? LIM_BURST : LIM_DIST;
        tick_o = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (hold_i) begin
            cnt_d = '0;
        end else if (cnt_q >= limit) begin
            tick_o = 1'b1;
            cnt_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int unsigned N_REF = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic burst_mode_i,
    input  logic dec_i,
    input  logic clr_i,
    output logic pending_o
);
    localparam int unsigned DW = $clog2(N_REF + 1);
    localparam logic [DW-1:0] FULL = DW'(N_REF);

    logic [DW-1:0] debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        if (clr_i) begin
            debt_d = '0;
        end else if (tick_i && burst_mode_i) begin
            debt_d = dec_i ? FULL - 1'b1 : FULL;
        end else if (tick_i && !dec_i) begin
            if (debt_q != FULL) debt_d = debt_q + 1'b1;
        end else if (!tick_i && dec_i) begin
            if (debt_q != '0) debt_d = debt_q - 1'b1;
        end
    end

    assign pending_o = (debt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
    import refresh_sched_pkg::*;
#(
    parameter int unsigned T_RP = 2,
    parameter int unsigned T_RC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode_i,
    input  logic grant_i,
    input  logic sref_req_i,
    input  logic pending_i,
    output logic ref_req_o,
    output logic pre_all_o,
    output logic aref_o,
    output logic sref_enter_o,
    output logic cke_o,
    output logic ready_o,
    output logic debt_clr_o,
    output logic timer_hold_o
);
    localparam int unsigned WMAX = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int unsigned WW   = $clog2(WMAX + 1);
    localparam logic [WW-1:0] LD_RP   = WW'(T_RP - 2);
    localparam logic [WW-1:0] LD_RC   = WW'(T_RC - 2);
    localparam logic [WW-1:0] LD_EXIT = WW'(T_RC - 1);

    typedef struct packed {
        sched_state_e    st;
        logic            sr;
        logic [WW-1:0]   wcnt;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (sref_req_i) begin
                    s_d.st = ST_REQ;
                    s_d.sr = 1'b1;
                end else if (pending_i) begin
                    s_d.st = ST_REQ;
                    s_d.sr = 1'b0;
                end
            end
            ST_REQ: begin
                if (grant_i) s_d.st = ST_PRE;
            end
            ST_PRE: begin
                s_d.st   = ST_WAIT_RP;
                s_d.wcnt = LD_RP;
            end
            ST_WAIT_RP: begin
                if (s_q.wcnt == '0) s_d.st = s_q.sr ? ST_SR_ENTER : ST_AREF;
                else                s_d.wcnt = s_q.wcnt - 1'b1;
            end
            ST_AREF: begin
                s_d.st   = ST_WAIT_RC;
                s_d.wcnt = LD_RC;
            end
            ST_WAIT_RC: begin
                if (s_q.wcnt == '0)
                    s_d.st = (burst_mode_i && pending_i) ? ST_AREF : ST_IDLE;
                else
                    s_d.wcnt = s_q.wcnt - 1'b1;
            end
            ST_SR_ENTER: begin
                s_d.st = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (!sref_req_i) begin
                    s_d.st   = ST_SR_EXIT;
                    s_d.wcnt = LD_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (s_q.wcnt == '0) begin
                    s_d.st = ST_IDLE;
                    s_d.sr = 1'b0;
                end else begin
                    s_d.wcnt = s_q.wcnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.sr   <= 1'b0;
            s_q.wcnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic in_sr;
    assign in_sr        = (s_q.st == ST_SR_ENTER) || (s_q.st == ST_SR_HOLD)
                       || (s_q.st == ST_SR_EXIT);
    assign ref_req_o    = (s_q.st != ST_IDLE);
    assign pre_all_o    = (s_q.st == ST_PRE);
    assign aref_o       = (s_q.st == ST_AREF);
    assign sref_enter_o = (s_q.st == ST_SR_ENTER);
    assign cke_o        = !((s_q.st == ST_SR_ENTER) || (s_q.st == ST_SR_HOLD));
    assign ready_o      = !in_sr;
    assign debt_clr_o   = (s_q.st == ST_SR_HOLD) || (s_q.st == ST_SR_EXIT);
    assign timer_hold_o = in_sr;
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
    parameter int unsigned T_REF_CYC = 3_200_000,
    parameter int unsigned N_REF     = 4096,
    parameter int unsigned T_RP      = 2,
    parameter int unsigned T_RC      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode_i,
    input  logic grant_i,
    input  logic sref_req_i,
    output logic ref_req_o,
    output logic pre_all_o,
    output logic aref_o,
    output logic sref_enter_o,
    output logic cke_o,
    output logic ready_o
);
    logic tick;
    logic pending;
    logic debt_clr;
    logic timer_hold;

    refresh_interval_timer #(
        .T_REF_CYC (T_REF_CYC),
        .N_REF     (N_REF)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode_i (burst_mode_i),
        .hold_i       (timer_hold),
        .tick_o       (tick)
    );

    refresh_debt #(
        .N_REF (N_REF)
    ) u_debt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .burst_mode_i (burst_mode_i),
        .dec_i        (aref_o),
        .clr_i        (debt_clr),
        .pending_o    (pending)
    );

    refresh_seq_fsm #(
        .T_RP (T_RP),
        .T_RC (T_RC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode_i (burst_mode_i),
        .grant_i      (grant_i),
        .sref_req_i   (sref_req_i),
        .pending_i    (pending),
        .ref_req_o    (ref_req_o),
        .pre_all_o    (pre_all_o),
        .aref_o       (aref_o),
        .sref_enter_o (sref_enter_o),
        .cke_o        (cke_o),
        .ready_o      (ready_o),
        .debt_clr_o   (debt_clr),
        .timer_hold_o (timer_hold)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned T_RP = 2,
    parameter int unsigned T_RC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic sref_req_i,
    input logic ref_req_o,
    input logic pre_all_o,
    input logic aref_o,
    input logic sref_enter_o,
    input logic cke_o,
    input logic ready_o
);
    logic [15:0] since_pre_q, since_aref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q  <= 16'hFFFF;
            since_aref_q <= 16'hFFFF;
        end else begin
            since_pre_q  <= pre_all_o ? 16'd1
                          : (since_pre_q == 16'hFFFF ? since_pre_q : since_pre_q + 16'd1);
            since_aref_q <= aref_o ? 16'd1
                          : (since_aref_q == 16'hFFFF ? since_aref_q : since_aref_q + 16'd1);
        end
    end

    // R6
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_all_o, aref_o, sref_enter_o}));

    // R3
    aref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aref_o |-> ((since_pre_q == 16'(T_RP)) || (since_aref_q == 16'(T_RC))));

    // R3
    sref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sref_enter_o |-> (since_pre_q == 16'(T_RP)));

    // R4
    no_cmd_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req_o |-> !(pre_all_o || aref_o || sref_enter_o));

    // R4
    pre_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |-> $past(grant_i));

    // R7
    sref_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sref_enter_o |-> !cke_o);

    // R7
    quiet_in_sref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> !(pre_all_o || aref_o));

    // R7
    hold_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && sref_req_i) |=> !cke_o);

    // R8
    ready_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> cke_o);

    // R8
    cke_rise_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> !ready_o);
endmodule

bind sdram_refresh_sched refresh_sched_chk #(
    .T_RP (T_RP),
    .T_RC (T_RC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_i      (grant_i),
    .sref_req_i   (sref_req_i),
    .ref_req_o    (ref_req_o),
    .pre_all_o    (pre_all_o),
    .aref_o       (aref_o),
    .sref_enter_o (sref_enter_o),
    .cke_o        (cke_o),
    .ready_o      (ready_o)
);

// File: tb/tb_sdram_refresh_sched.sv
module tb_sdram_refresh_sched;
    localparam int unsigned TB_TREF = 160;
    localparam int unsigned TB_N    = 8;
    localparam int unsigned TB_RP   = 3;
    localparam int unsigned TB_RC   = 6;
    localparam int TB_INT = TB_TREF / TB_N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_mode_i = 1'b0;
    logic grant_i = 1'b0;
    logic sref_req_i = 1'b0;
    logic ref_req_o, pre_all_o, aref_o, sref_enter_o, cke_o, ready_o;

    always #10 clk = ~clk;

    sdram_refresh_sched #(
        .T_REF_CYC (TB_TREF),
        .N_REF     (TB_N),
        .T_RP      (TB_RP),
        .T_RC      (TB_RC)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode_i (burst_mode_i),
        .grant_i      (grant_i),
        .sref_req_i   (sref_req_i),
        .ref_req_o    (ref_req_o),
        .pre_all_o    (pre_all_o),
        .aref_o       (aref_o),
        .sref_enter_o (sref_enter_o),
        .cke_o        (cke_o),
        .ready_o      (ready_o)
    );

    int cyc = 0;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int n_chk = 0;
    int n_fail = 0;
    int mon_chk = 0;
    int mon_fail = 0;
    int last_pre = -1000;
    int last_aref = -1000;
    bit done = 1'b0;

    // R3 / R2: every refresh strobe sits T_RP after a precharge or T_RC after the previous refresh
    always @(negedge clk) begin
        if (!rst_n) begin
            last_pre  = -1000;
            last_aref = -1000;
        end else begin
            if (aref_o) begin
                mon_chk++;
                if (!((cyc - last_pre == int'(TB_RP)) ||
                      ((cyc - last_aref == int'(TB_RC)) && (last_aref > last_pre)))) begin
                    mon_fail++;
                    $display("FAIL R3 aref spacing at cycle %0d: since_pre=%0d since_aref=%0d expected %0d or %0d",
                             cyc, cyc - last_pre, cyc - last_aref, TB_RP, TB_RC);
                end
                last_aref = cyc;
            end
            if (pre_all_o) last_pre = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic burst, input logic grant);
        rst_n = 1'b0;
        burst_mode_i = burst;
        grant_i = grant;
        sref_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wait_aref(output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (aref_o) begin
                t = cyc;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic        burst;
        logic [31:0] grant_at;
        logic [31:0] win;
        logic [31:0] lo;
        logic [31:0] hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 32'd0,     32'd160, 32'd7,  32'd7},   // R1 distributed, grant held
        '{1'b1, 32'd0,     32'd320, 32'd8,  32'd8},   // R2 one burst
        '{1'b1, 32'd0,     32'd480, 32'd16, 32'd16},  // R2 two bursts
        '{1'b0, 32'd400,   32'd700, 32'd20, 32'd24},  // R5 distributed debt capped
        '{1'b1, 32'd500,   32'd630, 32'd8,  32'd8},   // R5 burst debt capped
        '{1'b0, 32'd99999, 32'd400, 32'd0,  32'd0}    // R4 no grant, no command
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk + 1, n_fail + mon_fail);
            $finish;
        end
    end

    initial begin
        int t;
        int t0;
        int cnt;
        bit bad;

        // R9 reset state
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(cke_o == 1'b1 && ready_o == 1'b1, "R9 cke/ready in reset", {cke_o, ready_o}, 3);
        chk({ref_req_o, pre_all_o, aref_o, sref_enter_o} == 4'b0, "R9 strobes in reset",
            {ref_req_o, pre_all_o, aref_o, sref_enter_o}, 0);

        // vector table
        for (int v = 0; v < 6; v++) begin
            do_reset(VECS[v].burst, VECS[v].grant_at == 0);
            cnt = 0;
            while (cyc < int'(VECS[v].win)) begin
                @(negedge clk);
                if (aref_o) cnt++;
                if (cyc >= int'(VECS[v].grant_at)) grant_i = 1'b1;
            end
            chk(cnt >= int'(VECS[v].lo) && cnt <= int'(VECS[v].hi),
                $sformatf("R1/R2/R4/R5 vector %0d aref count", v), cnt, int'(VECS[v].lo));
            if (v == 5)
                chk(ref_req_o == 1'b1, "R4 request held without grant", ref_req_o, 1);
        end

        // R1 first and second distributed refresh
        do_reset(1'b0, 1'b1);
        wait_aref(t);
        chk(t == TB_INT + 5, "R1 first distributed aref", t, TB_INT + 5);
        wait_aref(t0);
        chk(t0 - t == TB_INT, "R1 distributed spacing", t0 - t, TB_INT);

        // R2 burst run timing
        do_reset(1'b1, 1'b1);
        wait_aref(t);
        chk(t == int'(TB_TREF) + 5, "R2 first burst aref", t, TB_TREF + 5);
        t0 = t;
        for (int k = 0; k < int'(TB_N) - 1; k++) wait_aref(t);
        chk(t - t0 == (int'(TB_N) - 1) * int'(TB_RC), "R2 burst run length", t - t0,
            (TB_N - 1) * TB_RC);
        wait_aref(t);
        chk(t == 2 * int'(TB_TREF) + 5, "R2 next burst one period later", t, 2 * TB_TREF + 5);

        // R7 / R8 self refresh
        do_reset(1'b0, 1'b1);
        step_to(5);
        sref_req_i = 1'b1;
        step_to(7);
        chk(pre_all_o == 1'b1, "R7 precharge before self refresh", pre_all_o, 1);
        step_to(10);
        chk(sref_enter_o == 1'b1 && cke_o == 1'b0, "R7 entry with cke low",
            {sref_enter_o, cke_o}, 2);
        bad = 1'b0;
        while (cyc < 100) begin
            @(negedge clk);
            if (cke_o || ready_o || pre_all_o || aref_o || sref_enter_o) bad = 1'b1;
        end
        chk(!bad, "R7 quiet with cke low while held", bad, 0);
        sref_req_i = 1'b0;
        step_to(101);
        chk(cke_o == 1'b1 && ready_o == 1'b0, "R8 cke up, not ready", {cke_o, ready_o}, 2);
        step_to(100 + int'(TB_RC));
        chk(ready_o == 1'b0, "R8 not ready before T_RC", ready_o, 0);
        step_to(101 + int'(TB_RC));
        chk(ready_o == 1'b1, "R8 ready after T_RC", ready_o, 1);
        wait_aref(t);
        chk(t == 101 + int'(TB_RC) + TB_INT + 5, "R8 timer restarted after exit", t,
            101 + TB_RC + TB_INT + 5);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    end
endmodule